// File: doc/BRIEF.md
# Three-Channel Residue Checker for an Adder/Subtractor

This block wraps a W-bit adder/subtractor with three independent residue channels so that any corruption of the delivered result is flagged. Each channel reduces the two operands modulo its own modulus. It combines those residues with the carry-in and with the main adder's carry or borrow to predict the residue of the result. One cycle later it compares that prediction with a residue taken from the result that actually left the block.

The three moduli are 7, 2^(W/2)−1 and 2^(W/2). They are pairwise coprime when W/2 is not a multiple of 3, and their product exceeds 2^W. So two results that agree in all three residues are equal, and every nonzero corruption of the result is caught. A fault-injection mask flips chosen result bits on their way out so that the checking path can be exercised in place.

Timing: operands are taken on one clock edge. The result and carry appear after that edge. The per-channel flags and the combined flag appear one edge later.

Top module: `mres_add_checker`

## Requirements
- R1: With `sub_sel`=0, the `res`/`carry_out` pair equals op_a + op_b + cin, split into W result bits and the carry above them. It is registered, so it is visible after the first clock edge that follows the inputs.
- R2: With `sub_sel`=1, `res` equals (op_a − op_b − cin) modulo 2^W, where cin acts as a borrow-in. `carry_out`=1 exactly when op_a < op_b + cin. The timing is the same as in R1.
- R3: `err_ch[0]` checks modulo 7, `err_ch[1]` checks modulo 2^(W/2)−1 and `err_ch[2]` checks modulo 2^(W/2). Each bit is 1 exactly when the delivered `res` and the true result differ modulo that channel's modulus. The bit is valid one edge after the `res` it judges.
- R4: `flip_mask` is XORed onto the result in the same register stage, so a 1 in bit i inverts `res[i]`.
- R5: When the `flip_mask` that went with a result was all zeros, `err_any` stays 0 for that result, in both modes and for all operands.
- R6: When the `flip_mask` that went with a result was nonzero, `err_any` is 1 for that result.
- R7: When exactly one bit is set in `flip_mask`, both odd channels, `err_ch[0]` and `err_ch[1]`, raise their flags.
- R8: `err_any` equals the OR of the three `err_ch` bits in every cycle.
- R9: While `rst_n` is low, `res`, `carry_out`, `err_ch` and `err_any` are all 0, whatever the inputs.
- R10: `err_ch[2]` is 1 exactly when the flip mask touched at least one of the low W/2 result bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| cin | input | 1 | Carry-in (add) or borrow-in (subtract) |
| sub_sel | input | 1 | 0 = add, 1 = subtract |
| flip_mask | input | W | Result bits to invert, for fault injection |
| res | output | W | Registered result, after the flip mask |
| carry_out | output | 1 | Registered carry (add) or borrow (subtract) |
| err_ch | output | 3 | Per-channel mismatch flags: moduli 7, 2^(W/2)−1, 2^(W/2) |
| err_any | output | 1 | OR of the channel flags |

## Verification
The block has two pipeline positions. In any cycle the flags judge the previous result while a new result, possibly with its own injected flip, is being registered. The bench therefore streams back-to-back operations that alternate clean and corrupted results, add and subtract, and carry and borrow corners. It checks every cycle that each flag lines up with the result of one cycle earlier and never with the one beside it. Corruptions whose size is exactly 7, 255 or 256 are placed so that one channel is blind while the others must fire. The expected flags come from ordinary integer remainders of the true and delivered values.

// File: rtl/mres_pkg.sv
package mres_pkg;

  typedef enum logic [1:0] {
    CH_SEVEN    = 2'd0,
    CH_HALF_ODD = 2'd1,
    CH_HALF_POW = 2'd2
  } chan_kind_e;

  localparam int NUM_CH = 3;

  // Modulus of a channel for half-word width 'half'
  function automatic int chan_modulus(chan_kind_e k, int half);
    case (k)
      CH_SEVEN:    return 7;
      CH_HALF_ODD: return (1 << half) - 1;
      default:     return 1 << half;
    endcase
  endfunction

  // Value of 2^w reduced by the channel modulus (weight of the carry/borrow)
  function automatic int wrap_weight(chan_kind_e k, int w);
    case (k)
      CH_SEVEN: begin
        case (w % 3)
          0:       return 1;
          1:       return 2;
          default: return 4;
        endcase
      end
      CH_HALF_ODD: return 1;
      default:     return 0;
    endcase
  endfunction

endpackage

// File: rtl/mres_adder.sv
module mres_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub_sel,
  output logic [W-1:0] sum,
  output logic         carry
);
  localparam int WP = W + 1;

  logic [W:0] full;

  always_comb begin
    if (sub_sel)
      full = {1'b0, a} - {1'b0, b} - WP'(cin);
    else
      full = {1'b0, a} + {1'b0, b} + WP'(cin);
  end

  assign sum   = full[W-1:0];
  assign carry = full[W];

endmodule

// File: rtl/mres_residue.sv
module mres_residue
  import mres_pkg::*;
#(
  parameter int         W    = 16,
  parameter chan_kind_e KIND = CH_SEVEN
) (
  input  logic [W-1:0]   value,
  output logic [W/2-1:0] residue
);
  localparam int H  = W / 2;
  localparam int HP = H + 1;
  localparam int NG = (W + 2) / 3;

  // Sum of 3-bit groups, then end-around folding down to 0..6
  function automatic logic [2:0] fold_seven(logic [W-1:0] v);
    logic [W+2:0] ext;
    logic [7:0]   acc;
    logic [4:0]   s2;
    logic [3:0]   s3;
    logic [2:0]   s4;
    ext = {3'b000, v};
    acc = '0;
    for (int i = 0; i < NG; i++) acc = acc + 8'(ext[3*i +: 3]);
    s2 = 5'(acc[2:0]) + 5'(acc[5:3]) + 5'(acc[7:6]);
    s3 = 4'(s2[2:0]) + 4'(s2[4:3]);
    s4 = s3[2:0] + 3'(s3[3]);
    return (s4 == 3'd7) ? 3'd0 : s4;
  endfunction

  // Two halves added with the carry wrapped round; all-ones stands for zero
  function automatic logic [H-1:0] fold_odd(logic [W-1:0] v);
    logic [H:0] t;
    logic [H:0] s;
    t = {1'b0, v[H-1:0]} + {1'b0, v[W-1:H]};
    s = {1'b0, t[H-1:0]} + HP'(t[H]);
    return (&s[H-1:0]) ? '0 : s[H-1:0];
  endfunction

  generate
    if (KIND == CH_SEVEN) begin : g_seven
      assign residue = {{(H-3){1'b0}}, fold_seven(value)};
    end else if (KIND == CH_HALF_ODD) begin : g_odd
      assign residue = fold_odd(value);
    end else begin : g_pow
      logic unused_hi_bits;
      assign unused_hi_bits = ^value[W-1:H];
      assign residue = value[H-1:0];
    end
  endgenerate

endmodule

// File: rtl/mres_channel.sv
module mres_channel
  import mres_pkg::*;
#(
  parameter int         W    = 16,
  parameter chan_kind_e KIND = CH_SEVEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         cin,
  input  logic         sub_sel,
  input  logic         carry,
  input  logic [W-1:0] res_q,
  output logic         mism,
  output logic         flag_q
);
  localparam int H  = W / 2;
  localparam int PW = H + 3;
  localparam int M  = chan_modulus(KIND, H);
  localparam int K  = wrap_weight(KIND, W);
  localparam logic [PW-1:0] MV = PW'(M);
  localparam logic [PW-1:0] KV = PW'(K);

  logic [H-1:0]  ra, rb, r_act, pred_q;
  logic [PW-1:0] raw_pred;

  mres_residue #(.W(W), .KIND(KIND)) u_ra  (.value(op_a),  .residue(ra));
  mres_residue #(.W(W), .KIND(KIND)) u_rb  (.value(op_b),  .residue(rb));
  mres_residue #(.W(W), .KIND(KIND)) u_act (.value(res_q), .residue(r_act));

  // Input below 4*M brought into 0..M-1
  function automatic logic [PW-1:0] reduce(logic [PW-1:0] x);
    logic [PW-1:0] y;
    y = x;
    for (int i = 0; i < 3; i++) if (y >= MV) y = y - MV;
    return y;
  endfunction

  // add: ra + rb + cin - carry*2^W ; sub: ra - rb - cin + borrow*2^W
  always_comb begin
    if (sub_sel)
      raw_pred = PW'(ra) + (MV - PW'(rb)) + (MV - PW'(cin)) + (carry ? KV : '0);
    else
      raw_pred = PW'(ra) + PW'(rb) + PW'(cin) + (carry ? (MV - KV) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_q <= '0;
      flag_q <= 1'b0;
    end else begin
      pred_q <= H'(reduce(raw_pred));
      flag_q <= mism;
    end
  end

  // plain XOR equality test between predicted and generated residues
  assign mism = |(pred_q ^ r_act);

  AST_ACT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(r_act) < MV); // R3
  AST_PRED_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(pred_q) < MV); // R3

endmodule

// File: rtl/mres_add_checker.sv
module mres_add_checker
  import mres_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         cin,
  input  logic         sub_sel,
  input  logic [W-1:0] flip_mask,
  output logic [W-1:0] res,
  output logic         carry_out,
  output logic [2:0]   err_ch,
  output logic         err_any
);
  localparam int H = W / 2;

  logic [W-1:0]      raw_sum;
  logic              raw_carry;
  logic [W-1:0]      res_q;
  logic [NUM_CH-1:0] mism_vec;
  logic [NUM_CH-1:0] flag_vec;
  // injection events, aligned with the registered result, for the assertions
  logic              inj_any_q, inj_one_q, inj_lo_q;

  mres_adder #(.W(W)) u_add (
    .a(op_a), .b(op_b), .cin(cin), .sub_sel(sub_sel),
    .sum(raw_sum), .carry(raw_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q     <= '0;
      carry_out <= 1'b0;
      err_any   <= 1'b0;
      inj_any_q <= 1'b0;
      inj_one_q <= 1'b0;
      inj_lo_q  <= 1'b0;
    end else begin
      res_q     <= raw_sum ^ flip_mask;
      carry_out <= raw_carry;
      err_any   <= |mism_vec;
      inj_any_q <= |flip_mask;
      inj_one_q <= $onehot(flip_mask);
      inj_lo_q  <= |flip_mask[H-1:0];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      mres_channel #(.W(W), .KIND(chan_kind_e'(gi))) u_ch (
        .clk(clk), .rst_n(rst_n),
        .op_a(op_a), .op_b(op_b), .cin(cin), .sub_sel(sub_sel),
        .carry(raw_carry), .res_q(res_q),
        .mism(mism_vec[gi]), .flag_q(flag_vec[gi])
      );
    end
  endgenerate

  assign res    = res_q;
  assign err_ch = flag_vec;

  AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    err_any == |err_ch); // R8
  AST_CLEAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_any_q |=> !err_any); // R5
  AST_FLIP_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
    inj_any_q |=> err_any); // R6
  AST_SINGLE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    inj_one_q |=> (err_ch[0] && err_ch[1])); // R7
  AST_LOW_HALF_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    inj_lo_q |=> err_ch[2]); // R10
  AST_HIGH_HALF_BLIND: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_lo_q |=> !err_ch[2]); // R10

endmodule

// File: tb/sim_mres_add_checker.sv
`timescale 1ns/1ps
module sim_mres_add_checker;
  localparam int W = 16;
  localparam int H = W / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0, m = '0;
  logic         c = 1'b0, s = 1'b0;
  logic [W-1:0] res;
  logic         carry_out;
  logic [2:0]   err_ch;
  logic         err_any;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // expected pipeline: stage 1 = result, stage 2 = flags
  logic [W-1:0] s1_sum = '0, s1_mask = '0, s2_mask = '0;
  bit           s1_cout = 0, s1_sub = 0;
  bit [2:0]     s1_fl = '0, s2_fl = '0;

  always #2 clk = ~clk;

  mres_add_checker #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .cin(c), .sub_sel(s),
    .flip_mask(m), .res(res), .carry_out(carry_out), .err_ch(err_ch),
    .err_any(err_any)
  );

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [W-1:0] ai, bi, input bit ci, si,
                       output logic [W-1:0] sm, output bit co);
    longint t;
    if (si) t = longint'(ai) - longint'(bi) - longint'(ci);
    else    t = longint'(ai) + longint'(bi) + longint'(ci);
    co = si ? (t < 0) : (t >= (longint'(1) << W));
    sm = W'(t);
  endtask

  function automatic bit [2:0] flags(logic [W-1:0] good, logic [W-1:0] mk);
    longint g, d, m1, m2;
    g  = longint'(good);
    d  = longint'(good ^ mk);
    m1 = (longint'(1) << H) - 1;
    m2 = longint'(1) << H;
    return {(d % m2) != (g % m2), (d % m1) != (g % m1), (d % 7) != (g % 7)};
  endfunction

  task automatic cycle(input logic [W-1:0] ai, bi, input bit ci, si,
                       input logic [W-1:0] mi);
    logic [W-1:0] sm;
    bit co;
    @(negedge clk);
    check(res == s1_sum, (s1_mask != 0) ? "R4" : (s1_sub ? "R2" : "R1"), "res",
          res, s1_sum);
    check(carry_out == s1_cout, s1_sub ? "R2" : "R1", "carry_out", carry_out, s1_cout);
    check(err_ch == s2_fl, "R3", "err_ch", err_ch, s2_fl);
    check(err_any == |err_ch, "R8", "err_any vs OR", err_any, |err_ch);
    if (s2_mask == 0) check(err_any == 1'b0, "R5", "err_any clean", err_any, 0);
    else              check(err_any == 1'b1, "R6", "err_any flipped", err_any, 1);
    if ($onehot(s2_mask))
      check(err_ch[1:0] == 2'b11, "R7", "odd channels", err_ch[1:0], 3);
    check(err_ch[2] == (|s2_mask[H-1:0]), "R10", "low-half channel", err_ch[2],
          |s2_mask[H-1:0]);
    s2_fl   = s1_fl;
    s2_mask = s1_mask;
    model(ai, bi, ci, si, sm, co);
    s1_sum  = sm ^ mi;
    s1_cout = co;
    s1_sub  = si;
    s1_mask = mi;
    s1_fl   = flags(sm, mi);
    a = ai; b = bi; c = ci; s = si; m = mi;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R9: reset holds everything at zero even with busy inputs
    a = 16'hFFFF; b = 16'h1234; c = 1'b1; s = 1'b0; m = 16'h00F0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(res == '0, "R9", "res in reset", res, 0);
    check(carry_out == 1'b0, "R9", "carry_out in reset", carry_out, 0);
    check(err_ch == 3'b000, "R9", "err_ch in reset", err_ch, 0);
    check(err_any == 1'b0, "R9", "err_any in reset", err_any, 0);
    a = '0; b = '0; c = 1'b0; s = 1'b0; m = '0;
    rst_n = 1'b1;

    // R1 carry corners
    cycle(16'hFFFF, 16'hFFFF, 1, 0, 0);
    cycle(16'h0000, 16'h0000, 0, 0, 0);
    cycle(16'hFFFF, 16'h0000, 1, 0, 0);
    cycle(16'h8000, 16'h8000, 0, 0, 0);
    // R2 borrow corners
    cycle(16'h0000, 16'h0001, 0, 1, 0);
    cycle(16'h0005, 16'h0005, 0, 1, 0);
    cycle(16'h0005, 16'h0005, 1, 1, 0);
    cycle(16'h0000, 16'hFFFF, 1, 1, 0);
    // R3: corruption sizes that blind exactly one channel
    cycle(16'h0000, 16'h0000, 0, 0, 16'h0007);
    cycle(16'h0000, 16'h0000, 0, 0, 16'h00FF);
    cycle(16'h0000, 16'h0000, 0, 0, 16'h0100);
    cycle(16'h0000, 16'h0000, 0, 0, 16'hFFFF);
    cycle(16'h0000, 16'h0000, 0, 0, 0);
    // R7: every single-bit flip, both modes, back to back
    for (int i = 0; i < W; i++) begin
      cycle(W'($urandom), W'($urandom), 1'($urandom), 0, W'(1) << i);
      cycle(W'($urandom), W'($urandom), 1'($urandom), 1, W'(1) << i);
    end
    // R10: flips confined to the high half
    for (int i = 0; i < 40; i++)
      cycle(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom),
            W'($urandom) & 16'hFF00);
    // R5/R6: random mix of clean and multi-bit corrupted results
    for (int i = 0; i < 400; i++)
      cycle(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom),
            (($urandom % 3) == 0) ? W'(0) : W'($urandom));
    for (int i = 0; i < 3; i++) cycle('0, '0, 0, 0, '0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule